// File: doc/BRIEF.md
# Paged memory-window chip-select decoder

This block turns a 20-bit processor address into a single device select for the main DRAM, a two-part frame store window, a paged flash-disk window, or a small block of display control registers in I/O space. The frame store window sits inside the DRAM range and takes priority over it. The frame store window is made of two 64 KB parts, and each part has an enable bit in a programmable range register. When a part is disabled, accesses to it fall through to DRAM. Software can then copy one part of the screen image into the DRAM that lies underneath the other part with a block move, and copy it back later.

The flash disk appears through a fixed 16 KB window. An 8-bit page latch supplies the flash address bits from bit 14 upward, so the window can reach a 4 MB device in 256 pages. A 2 MB device uses 128 of them. The top bit of the page latch also drives a status LED. The page latch and the range register are written as single I/O locations. The selects and the extended flash address are combinational from the address and the stored configuration. Bus timing and wait states are handled elsewhere.

Top module: `mem_window_decoder`

## Requirements
- R1: For a memory access (`mem_i`=1, `io_i`=0) to an address below 0xC0000, `dram_sel_o` is 1 unless the frame store claims that address.
- R2: `fs_sel_o` is 1 for a memory access to 0xA0000..0xAFFFF when range bit 0 is set, and to 0xB0000..0xBFFFF when range bit 1 is set. Otherwise that address goes to DRAM.
- R3: The range register is bits [1:0] of an I/O write to 0x211. It resets to 2'b11, which enables the whole window. The value 2'b00 sends the entire 0xA0000..0xBFFFF window to DRAM.
- R4: `flash_sel_o` is 1 for a memory access to 0xC8000..0xCBFFF and for no other address.
- R5: `flash_addr_o` (22 bits) equals {page latch, address bits [13:0]}.
- R6: The page latch is loaded from `wdata_i` by an I/O write to 0x210, and the new value appears from the cycle after the write. The latch resets to 0.
- R7: `led_o` equals bit 7 of the page latch.
- R8: `dreg_sel_o` is 1 only for an I/O access (`io_i`=1) to 0x200..0x20F.
- R9: At most one select is 1 at any time. A memory access to an unmapped address asserts no select. An I/O access never asserts a memory select, even when `mem_i` is also high. With no access, every select is 0.
- R10: An I/O read (`wr_i`=0) of 0x210 or 0x211 leaves both registers unchanged. A write with `io_i`=0 to those addresses also leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_i | input | 1 | Memory access in progress |
| io_i | input | 1 | I/O access in progress (takes precedence over mem_i) |
| wr_i | input | 1 | Access is a write |
| addr_i | input | 20 | Processor address |
| wdata_i | input | 8 | Write data for configuration registers |
| dram_sel_o | output | 1 | Main DRAM select |
| fs_sel_o | output | 1 | Frame store select |
| flash_sel_o | output | 1 | Flash-disk window select |
| dreg_sel_o | output | 1 | Display register block select |
| flash_addr_o | output | 22 | Extended flash address |
| led_o | output | 1 | Status LED, top page bit |

## Verification
The bench builds the decoder with its default parameters: a 20-bit address, an 8-bit page latch, a 14-bit flash window and two frame store parts. With these values the whole memory map can be swept at a 4 KB stride under each of the four range-register settings. Every region edge is also probed at the addresses one below and one above it. The small page latch lets the sweep cover the page values at both ends and at the LED boundary (0x7F and 0x80). Accesses that must be ignored are confirmed by reading the flash address and the LED at the ports afterwards.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int unsigned ADDR_W = 20;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    RGN_NONE  = 3'd0,
    RGN_DRAM  = 3'd1,
    RGN_FS    = 3'd2,
    RGN_FLASH = 3'd3,
    RGN_DREG  = 3'd4
  } region_e;

  localparam addr_t DRAM_END_DEF   = 20'hC0000;
  localparam addr_t FS_BASE_DEF    = 20'hA0000;
  localparam addr_t FLASH_BASE_DEF = 20'hC8000;
  localparam addr_t DREG_BASE_DEF  = 20'h00200;
  localparam addr_t PAGE_IO_DEF    = 20'h00210;
  localparam addr_t RANGE_IO_DEF   = 20'h00211;
endpackage

// File: rtl/mwd_cfg_regs.sv
module mwd_cfg_regs
  import mwd_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned FS_PARTS = 2,
  parameter addr_t       PAGE_IO  = PAGE_IO_DEF,
  parameter addr_t       RANGE_IO = RANGE_IO_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                io_i,
  input  logic                wr_i,
  input  addr_t               addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [PAGE_W-1:0]   page_o,
  output logic [FS_PARTS-1:0] part_en_o
);
  logic io_wr;
  logic page_we;
  logic range_we;

  assign io_wr    = io_i & wr_i;
  assign page_we  = io_wr && (addr_i == PAGE_IO);
  assign range_we = io_wr && (addr_i == RANGE_IO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
    end else if (page_we) begin
      page_o <= wdata_i[PAGE_W-1:0];
    end
  end

  // reset value enables every part: whole window is frame store
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_en_o <= '1;
    end else if (range_we) begin
      part_en_o <= wdata_i[FS_PARTS-1:0];
    end
  end
endmodule

// File: rtl/mwd_fs_match.sv
module mwd_fs_match
  import mwd_pkg::*;
#(
  parameter int unsigned FS_PARTS = 2,
  parameter int unsigned PART_W   = 16,
  parameter addr_t       FS_BASE  = FS_BASE_DEF
) (
  input  logic [ADDR_W-PART_W-1:0] addr_hi_i,
  input  logic [FS_PARTS-1:0]      part_en_i,
  output logic                     hit_o
);
  localparam int unsigned HI_W = ADDR_W - PART_W;

  logic [FS_PARTS-1:0] part_hit;

  for (genvar p = 0; p < FS_PARTS; p++) begin : g_part
    localparam addr_t PART_BASE = FS_BASE + (addr_t'(p) << PART_W);
    localparam logic [HI_W-1:0] PART_TAG = PART_BASE[ADDR_W-1:PART_W];
    assign part_hit[p] = part_en_i[p] && (addr_hi_i == PART_TAG);
  end

  assign hit_o = |part_hit;
endmodule

// File: rtl/mwd_region_sel.sv
module mwd_region_sel
  import mwd_pkg::*;
#(
  parameter int unsigned WIN_W      = 14,
  parameter int unsigned DREG_W     = 4,
  parameter addr_t       DRAM_END   = DRAM_END_DEF,
  parameter addr_t       FLASH_BASE = FLASH_BASE_DEF,
  parameter addr_t       DREG_BASE  = DREG_BASE_DEF
) (
  input  logic    mem_i,
  input  logic    io_i,
  input  addr_t   addr_i,
  input  logic    fs_hit_i,
  output region_e region_o
);
  logic flash_hit;
  logic dram_hit;
  logic dreg_hit;

  assign flash_hit = addr_i[ADDR_W-1:WIN_W] == FLASH_BASE[ADDR_W-1:WIN_W];
  assign dram_hit  = addr_i < DRAM_END;
  assign dreg_hit  = addr_i[ADDR_W-1:DREG_W] == DREG_BASE[ADDR_W-1:DREG_W];

  // I/O cycles win over memory; frame store overrides DRAM
  always_comb begin
    region_o = RGN_NONE;
    if (io_i) begin
      if (dreg_hit) region_o = RGN_DREG;
    end else if (mem_i) begin
      if (fs_hit_i)       region_o = RGN_FS;
      else if (flash_hit) region_o = RGN_FLASH;
      else if (dram_hit)  region_o = RGN_DRAM;
    end
  end
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned WIN_W    = 14,
  parameter int unsigned FS_PARTS = 2,
  parameter int unsigned PART_W   = 16,
  localparam int unsigned FADDR_W = PAGE_W + WIN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mem_i,
  input  logic               io_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               dram_sel_o,
  output logic               fs_sel_o,
  output logic               flash_sel_o,
  output logic               dreg_sel_o,
  output logic [FADDR_W-1:0] flash_addr_o,
  output logic               led_o
);
  logic [PAGE_W-1:0]   page;
  logic [FS_PARTS-1:0] part_en;
  logic                fs_hit;
  region_e             region;

  mwd_cfg_regs #(
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .FS_PARTS(FS_PARTS)
  ) i_cfg_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .io_i     (io_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .page_o   (page),
    .part_en_o(part_en)
  );

  mwd_fs_match #(
    .FS_PARTS(FS_PARTS),
    .PART_W  (PART_W)
  ) i_fs_match (
    .addr_hi_i(addr_i[ADDR_W-1:PART_W]),
    .part_en_i(part_en),
    .hit_o    (fs_hit)
  );

  mwd_region_sel #(
    .WIN_W(WIN_W)
  ) i_region_sel (
    .mem_i   (mem_i),
    .io_i    (io_i),
    .addr_i  (addr_i),
    .fs_hit_i(fs_hit),
    .region_o(region)
  );

  assign dram_sel_o   = region == RGN_DRAM;
  assign fs_sel_o     = region == RGN_FS;
  assign flash_sel_o  = region == RGN_FLASH;
  assign dreg_sel_o   = region == RGN_DREG;
  assign flash_addr_o = {page, addr_i[WIN_W-1:0]};
  assign led_o        = page[PAGE_W-1];
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned WIN_W   = 14,
  localparam int unsigned FADDR_W = PAGE_W + WIN_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mem_i,
  input logic               io_i,
  input logic               wr_i,
  input logic [19:0]        addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               dram_sel_o,
  input logic               fs_sel_o,
  input logic               flash_sel_o,
  input logic               dreg_sel_o,
  input logic [FADDR_W-1:0] flash_addr_o,
  input logic               led_o
);
  assert_dram_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_sel_o |-> (mem_i && !io_i && addr_i < 20'hC0000));

  assert_fs_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_sel_o |-> (mem_i && !io_i && addr_i >= 20'hA0000 && addr_i <= 20'hBFFFF));

  assert_flash_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_sel_o |-> (mem_i && !io_i && addr_i >= 20'hC8000 && addr_i <= 20'hCBFFF));

  assert_flash_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_sel_o |-> (flash_addr_o[WIN_W-1:0] == addr_i[WIN_W-1:0]));

  assert_page_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_i && wr_i && addr_i == 20'h00210)
      |=> (flash_addr_o[FADDR_W-1:WIN_W] == $past(wdata_i[PAGE_W-1:0])));

  assert_led_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == flash_addr_o[FADDR_W-1]);

  assert_dreg_io_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreg_sel_o |-> (io_i && addr_i[19:4] == 16'h0020));

  assert_onehot_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dram_sel_o, fs_sel_o, flash_sel_o, dreg_sel_o}));

  assert_io_no_mem_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_i |-> !(dram_sel_o || fs_sel_o || flash_sel_o));

  assert_page_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_i && wr_i) |=> $stable(flash_addr_o[FADDR_W-1:WIN_W]));
endmodule

bind mem_window_decoder mwd_checker #(
  .DATA_W(DATA_W),
  .PAGE_W(PAGE_W),
  .WIN_W (WIN_W)
) i_mwd_checker (.*);

// File: tb/test_mem_window_decoder.sv
module test_mem_window_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_i = 1'b0;
  logic        io_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        dram_sel_o, fs_sel_o, flash_sel_o, dreg_sel_o, led_o;
  logic [21:0] flash_addr_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mem_window_decoder i_mem_window_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_i(mem_i), .io_i(io_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .dram_sel_o(dram_sel_o),
    .fs_sel_o(fs_sel_o), .flash_sel_o(flash_sel_o), .dreg_sel_o(dreg_sel_o),
    .flash_addr_o(flash_addr_o), .led_o(led_o)
  );

  // 0 none, 1 dram, 2 frame store, 3 flash, 4 display regs, 7 several
  function automatic int exp_code(logic io, logic mem, logic [19:0] a, logic [1:0] mask);
    if (io) return (a[19:4] == 16'h0020) ? 4 : 0;
    if (!mem) return 0;
    if (a >= 20'hA0000 && a <= 20'hAFFFF && mask[0]) return 2;
    if (a >= 20'hB0000 && a <= 20'hBFFFF && mask[1]) return 2;
    if (a >= 20'hC8000 && a <= 20'hCBFFF) return 3;
    if (a < 20'hC0000) return 1;
    return 0;
  endfunction

  function automatic int got_code();
    int n;
    n = int'(dram_sel_o) + int'(fs_sel_o) + int'(flash_sel_o) + int'(dreg_sel_o);
    if (n > 1) return 7;
    if (dram_sel_o) return 1;
    if (fs_sel_o) return 2;
    if (flash_sel_o) return 3;
    if (dreg_sel_o) return 4;
    return 0;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic probe(string req, logic io, logic mem, logic [19:0] a, logic [1:0] mask);
    @(negedge clk_i);
    io_i = io; mem_i = mem; wr_i = 1'b0; addr_i = a;
    #1;
    check(req, got_code(), exp_code(io, mem, a, mask));
  endtask

  task automatic io_write(logic [19:0] a, logic [7:0] d, logic io);
    @(negedge clk_i);
    io_i = io; mem_i = ~io; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    io_i = 1'b0; mem_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic check_page(string req, logic [7:0] page);
    @(negedge clk_i);
    io_i = 1'b0; mem_i = 1'b1; wr_i = 1'b0; addr_i = 20'hC9A5C;
    #1;
    check(req, int'(flash_addr_o), int'({page, 14'h1A5C}));
    check("R7 led", int'(led_o), int'(page[7]));
  endtask

  logic [19:0] edges [11] = '{20'h9FFFF, 20'hA0000, 20'hAFFFF, 20'hB0000, 20'hBFFFF,
                              20'hC0000, 20'hC7FFF, 20'hC8000, 20'hCBFFF, 20'hCC000,
                              20'hFFFFF};
  logic [7:0]  pages [5] = '{8'h01, 8'h7F, 8'h80, 8'hFF, 8'h00};

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state: page 0, whole frame store window enabled
    check_page("R6 reset page", 8'h00);
    probe("R3 reset full window lower", 1'b0, 1'b1, 20'hA0000, 2'b11);
    probe("R3 reset full window upper", 1'b0, 1'b1, 20'hBFFFF, 2'b11);
    probe("R9 idle no select", 1'b0, 1'b0, 20'hA0000, 2'b11);

    // map sweep under each range setting (R1 R2 R3 R4 R9)
    for (int m = 0; m < 4; m++) begin
      io_write(20'h00211, 8'(m), 1'b1);
      for (int a = 0; a < (1 << 20); a += 4096)
        probe("R1/R2/R4 sweep", 1'b0, 1'b1, 20'(a), 2'(m));
      foreach (edges[i]) probe("R2/R4 edge", 1'b0, 1'b1, edges[i], 2'(m));
    end

    // I/O space: display regs only, never a memory select (R8 R9)
    for (int a = 20'h001F0; a < 20'h00230; a++) begin
      probe("R8 io sweep", 1'b1, 1'b0, 20'(a), 2'b11);
      probe("R9 io with mem high", 1'b1, 1'b1, 20'(a), 2'b11);
    end
    probe("R9 io at frame store addr", 1'b1, 1'b1, 20'hA0000, 2'b11);
    probe("R9 io at flash addr", 1'b1, 1'b1, 20'hC8000, 2'b11);

    // page latch values and LED (R5 R6 R7)
    foreach (pages[i]) begin
      io_write(20'h00210, pages[i], 1'b1);
      check_page("R5/R6 page", pages[i]);
    end

    // ignored accesses (R10)
    io_write(20'h00210, 8'h9C, 1'b1);
    check_page("R6 page 9C", 8'h9C);
    @(negedge clk_i);
    io_i = 1'b1; mem_i = 1'b0; wr_i = 1'b0; addr_i = 20'h00210; wdata_i = 8'h11;
    @(negedge clk_i);
    io_i = 1'b0;
    check_page("R10 io read keeps page", 8'h9C);
    io_write(20'h00210, 8'h22, 1'b0);
    check_page("R10 mem write keeps page", 8'h9C);
    io_write(20'h00211, 8'h00, 1'b0);
    probe("R10 mem write keeps range", 1'b0, 1'b1, 20'hA0000, 2'b11);
    io_write(20'h00211, 8'h02, 1'b1);
    probe("R3 upper only lower->dram", 1'b0, 1'b1, 20'hA8000, 2'b10);
    probe("R3 upper only upper->fs", 1'b0, 1'b1, 20'hB8000, 2'b10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule